// File: doc/BRIEF.md
# Cluster Width and Layer Coincidence Trigger

This block turns one bunch crossing of binary strip hits into a short list of trigger primitives. A crossing is handed over as a 128-bit hit vector with a one-cycle `start` strobe. At that strobe the block also captures the mode, the width limit and the window size. It then drains the qualifying records one per clock, in ascending channel order.

In cluster mode, a cluster is a maximal run of adjacent hit channels. Narrow clusters point to stiff tracks, so only clusters whose width is within the programmed limit are passed on. Each record gives the lowest channel of the run and its width.

In coincidence mode, the chip's channels serve two stacked sensor layers that are bonded alternately. A lower-layer hit is reported when one or more upper-layer hits lie within the programmed strip window around it. At most 16 records leave per crossing. An end-of-crossing pulse carries the overflow flag.

Top module: `clus_coin_trig`

## Requirements
- R1: After reset, `busy`, `recValid`, `recLast`, `crossDone` and `crossOverflow` are all 0.
- R2: With `coinMode`=0, each maximal run of 1s in `hits` is one cluster. Its `recAddr` is the run's lowest channel index. Its `recWidth` is the run length, and a run of 8 or more channels reports 8.
- R3: With `coinMode`=0, a cluster produces a record only when its reported width is at most `maxWidth`. A `maxWidth` of 0 passes no cluster.
- R4: With `coinMode`=1, channel 2j is lower strip j and channel 2j+1 is upper strip j. A record with `recAddr`=2j is produced when lower strip j is hit and at least one upper strip k with |k-j| <= `winSize` (0..3) is hit. Its `recWidth` is the number of such upper strips. Strips beyond the edges do not exist. Upper hits alone produce nothing.
- R5: Records appear with `recValid` high for one clock each, on consecutive clocks, with strictly ascending `recAddr`. `recLast` is high only on the final record of the crossing.
- R6: `crossDone` pulses for exactly one clock per crossing. It falls on the clock of the final record, or on a clock of its own when no record qualifies.
- R7: At most 16 records are emitted per crossing, and these are the 16 lowest addresses. `crossOverflow` is 1 together with `crossDone` only when more than 16 qualify. Exactly 16 gives 0.
- R8: While `busy` is 1, `start` and changes on `hits`, `coinMode`, `maxWidth` and `winSize` have no effect: the running crossing's records are unchanged and no further crossing follows.
- R9: The first record, or `crossDone` for an empty crossing, is registered on the second rising edge after the edge that samples `start`. `busy` is high from the edge after `start` until `crossDone` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Crossing strobe; captures hits and settings when idle |
| hits | input | 128 | Binary hit vector of one crossing |
| coinMode | input | 1 | 0 = cluster width mode, 1 = two-layer coincidence mode |
| maxWidth | input | 4 | Largest cluster width passed (0..8) |
| winSize | input | 2 | Coincidence half-window in strips (0..3) |
| busy | output | 1 | Crossing being processed |
| recValid | output | 1 | Record strobe |
| recAddr | output | 7 | Record channel address |
| recWidth | output | 4 | Cluster width or count of matching upper strips |
| recLast | output | 1 | Final record of the crossing |
| crossDone | output | 1 | End-of-crossing pulse |
| crossOverflow | output | 1 | More than 16 records qualified in this crossing |

## Verification
The drain mask is the state that matters most. A bit left uncleared repeats an address or breaks the ascending order on the next clock. A wrong load drops or invents records in the first drained cycle, which is three clocks after `start`. A faulty record counter moves the point where the stream is cut to the wrong record, or raises `crossOverflow` at exactly 16 records. This shows on the `crossDone` clock of that same crossing. A captured setting that follows the live inputs during `busy` shows up as altered widths or addresses in records that are already streaming.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef struct packed {
    logic loadRegs;   // capture a crossing
    logic loadMask;   // fill the drain mask
    logic emit;       // send the lowest pending record
  } cct_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } cct_state_e;

endpackage

// File: rtl/cct_datapath.sv
module cct_datapath
  import cct_pkg::*;
#(
  parameter int N_CH    = 128,
  parameter int MAX_W   = 8,
  parameter int WIN_MAX = 3,
  localparam int ADDR_W = $clog2(N_CH),
  localparam int WID_W  = $clog2(MAX_W + 1),
  localparam int WIN_W  = $clog2(WIN_MAX + 1),
  localparam int COIN_W = $clog2(2 * WIN_MAX + 2),
  localparam int REC_W  = (WID_W > COIN_W) ? WID_W : COIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cct_ctl_t          ctl,
  input  logic [N_CH-1:0]   hitsIn,
  input  logic              coinModeIn,
  input  logic [WID_W-1:0]  maxWidthIn,
  input  logic [WIN_W-1:0]  winSizeIn,
  output logic              anyPend,
  output logic              morePend,
  output logic [ADDR_W-1:0] recAddr,
  output logic [REC_W-1:0]  recWidth
);

  localparam int N_LAY = N_CH / 2;

  logic [N_CH-1:0]  hitReg;
  logic             modeReg;
  logic [WID_W-1:0] maxWReg;
  logic [WIN_W-1:0] winReg;
  logic [N_CH-1:0]  pendMask;

  // captured crossing and settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitReg  <= '0;
      modeReg <= 1'b0;
      maxWReg <= '0;
      winReg  <= '0;
    end else if (ctl.loadRegs) begin
      hitReg  <= hitsIn;
      modeReg <= coinModeIn;
      maxWReg <= maxWidthIn;
      winReg  <= winSizeIn;
    end
  end

  // cluster side: run start and saturating run length per channel
  logic [N_CH+MAX_W-1:0] hitPad;
  logic [N_CH-1:0]       prevHit;
  logic [WID_W-1:0]      runLen [N_CH];

  assign hitPad  = {{MAX_W{1'b0}}, hitReg};
  assign prevHit = {hitReg[N_CH-2:0], 1'b0};

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      runLen[i] = '0;
      for (int k = 0; k < MAX_W; k++) begin
        if (hitPad[i+k] && (runLen[i] == WID_W'(k))) runLen[i] = runLen[i] + 1'b1;
      end
    end
  end

  // coincidence side: layers split from interleaved channels
  logic [N_LAY-1:0]           loLay;
  logic [N_LAY-1:0]           upLay;
  logic [N_LAY+2*WIN_MAX-1:0] upPad;
  logic [COIN_W-1:0]          coinCnt [N_LAY];

  for (genvar j = 0; j < N_LAY; j++) begin : g_layer
    assign loLay[j] = hitReg[2*j];
    assign upLay[j] = hitReg[2*j+1];
  end

  assign upPad = {{WIN_MAX{1'b0}}, upLay, {WIN_MAX{1'b0}}};

  always_comb begin
    for (int j = 0; j < N_LAY; j++) begin
      coinCnt[j] = '0;
      for (int d = 0; d <= 2 * WIN_MAX; d++) begin
        if (upPad[j+d] && (d >= WIN_MAX - int'(winReg)) && (d <= WIN_MAX + int'(winReg)))
          coinCnt[j] = coinCnt[j] + 1'b1;
      end
    end
  end

  // qualifying mask and per-channel record width
  logic [N_CH-1:0]  qualMask;
  logic [REC_W-1:0] widthArr [N_CH];

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      if (modeReg) begin
        qualMask[i] = ((i % 2) == 0) && loLay[i/2] && (coinCnt[i/2] != '0);
        widthArr[i] = ((i % 2) == 0) ? REC_W'(coinCnt[i/2]) : '0;
      end else begin
        qualMask[i] = hitReg[i] && !prevHit[i] && (runLen[i] <= maxWReg);
        widthArr[i] = REC_W'(runLen[i]);
      end
    end
  end

  // lowest pending channel
  logic [ADDR_W-1:0] pickIdx;
  logic [N_CH-1:0]   pendNext;

  always_comb begin
    pickIdx = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pendMask[i]) pickIdx = ADDR_W'(i);
    end
  end

  assign pendNext = pendMask & (pendMask - 1'b1);
  assign anyPend  = |pendMask;
  assign morePend = |pendNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
      recAddr  <= '0;
      recWidth <= '0;
    end else begin
      if (ctl.loadMask)  pendMask <= qualMask;
      else if (ctl.emit) pendMask <= pendNext;
      if (ctl.emit) begin
        recAddr  <= pickIdx;
        recWidth <= widthArr[pickIdx];
      end
    end
  end

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadRegs |=> $stable(hitReg) && $stable(modeReg) && $stable(winReg)); // R8
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit && $past(ctl.emit) |-> pickIdx > $past(pickIdx)); // R5
  AST_WIDTH_CUT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit && !modeReg |=> recWidth != '0 && recWidth <= REC_W'(maxWReg)); // R3
  AST_COIN_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit && modeReg |=> recAddr[0] == 1'b0 && recWidth != '0); // R4

endmodule

// File: rtl/cct_ctrl.sv
module cct_ctrl
  import cct_pkg::*;
#(
  parameter int MAX_REC = 16,
  localparam int CNT_W  = $clog2(MAX_REC + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     anyPend,
  input  logic     morePend,
  output cct_ctl_t ctl,
  output logic     busy,
  output logic     recValid,
  output logic     recLast,
  output logic     crossDone,
  output logic     crossOverflow
);

  cct_state_e       state;
  logic [CNT_W-1:0] recCnt;
  logic             capHit;
  logic             lastNow;
  logic             finishNow;

  assign capHit    = (recCnt == CNT_W'(MAX_REC - 1));
  assign lastNow   = !morePend || capHit;
  assign finishNow = (state == ST_EMIT) && (!anyPend || lastNow);

  assign ctl.loadRegs = (state == ST_IDLE) && start;
  assign ctl.loadMask = (state == ST_LOAD);
  assign ctl.emit     = (state == ST_EMIT) && anyPend;
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      recCnt        <= '0;
      recValid      <= 1'b0;
      recLast       <= 1'b0;
      crossDone     <= 1'b0;
      crossOverflow <= 1'b0;
    end else begin
      recValid      <= ctl.emit;
      recLast       <= ctl.emit && lastNow;
      crossDone     <= finishNow;
      crossOverflow <= ctl.emit && capHit && morePend;
      case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: begin
          recCnt <= '0;
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          if (ctl.emit) recCnt <= recCnt + 1'b1;
          if (finishNow) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    crossDone |=> !crossDone); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    recLast |-> crossDone && recValid); // R5
  AST_OVF_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    crossOverflow |-> recLast && crossDone); // R7
  AST_REC_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |-> recCnt < CNT_W'(MAX_REC)); // R7

endmodule

// File: rtl/clus_coin_trig.sv
module clus_coin_trig
  import cct_pkg::*;
#(
  parameter int N_CH    = 128,
  parameter int MAX_W   = 8,
  parameter int WIN_MAX = 3,
  parameter int MAX_REC = 16,
  localparam int ADDR_W = $clog2(N_CH),
  localparam int WID_W  = $clog2(MAX_W + 1),
  localparam int WIN_W  = $clog2(WIN_MAX + 1),
  localparam int COIN_W = $clog2(2 * WIN_MAX + 2),
  localparam int REC_W  = (WID_W > COIN_W) ? WID_W : COIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [N_CH-1:0]   hits,
  input  logic              coinMode,
  input  logic [WID_W-1:0]  maxWidth,
  input  logic [WIN_W-1:0]  winSize,
  output logic              busy,
  output logic              recValid,
  output logic [ADDR_W-1:0] recAddr,
  output logic [REC_W-1:0]  recWidth,
  output logic              recLast,
  output logic              crossDone,
  output logic              crossOverflow
);

  cct_ctl_t ctl;
  logic     anyPend;
  logic     morePend;

  cct_ctrl #(.MAX_REC(MAX_REC)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .anyPend      (anyPend),
    .morePend     (morePend),
    .ctl          (ctl),
    .busy         (busy),
    .recValid     (recValid),
    .recLast      (recLast),
    .crossDone    (crossDone),
    .crossOverflow(crossOverflow)
  );

  cct_datapath #(.N_CH(N_CH), .MAX_W(MAX_W), .WIN_MAX(WIN_MAX)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .hitsIn    (hits),
    .coinModeIn(coinMode),
    .maxWidthIn(maxWidth),
    .winSizeIn (winSize),
    .anyPend   (anyPend),
    .morePend  (morePend),
    .recAddr   (recAddr),
    .recWidth  (recWidth)
  );

endmodule

// File: tb/sim_clus_coin_trig.sv
module sim_clus_coin_trig;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] hits = '0;
  logic         coinMode = 1'b0;
  logic [3:0]   maxWidth = 4'd8;
  logic [1:0]   winSize = 2'd0;
  logic         busy, recValid, recLast, crossDone, crossOverflow;
  logic [6:0]   recAddr;
  logic [3:0]   recWidth;

  int checks = 0;
  int errors = 0;

  int expA [128];
  int expW [128];
  int expN;
  int gotA [128];
  int gotW [128];
  int gotL [128];

  clus_coin_trig u0 (
    .clk(clk), .rstN(rstN), .start(start), .hits(hits), .coinMode(coinMode),
    .maxWidth(maxWidth), .winSize(winSize), .busy(busy), .recValid(recValid),
    .recAddr(recAddr), .recWidth(recWidth), .recLast(recLast),
    .crossDone(crossDone), .crossOverflow(crossOverflow)
  );

  always #10 clk = ~clk;   // 50 MHz

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent model of the qualifying records
  task automatic buildExp(input logic [127:0] h, input bit cm, input int mw, input int win);
    expN = 0;
    if (!cm) begin
      for (int i = 0; i < 128; i++) begin
        if (h[i] && (i == 0 || !h[i-1])) begin
          int len = 0;
          while (i + len < 128 && h[i+len]) len++;
          if (len > 8) len = 8;
          if (len <= mw) begin
            expA[expN] = i; expW[expN] = len; expN++;
          end
        end
      end
    end else begin
      for (int j = 0; j < 64; j++) begin
        if (h[2*j]) begin
          int c = 0;
          for (int k = 0; k < 64; k++)
            if (h[2*k+1] && (k - j <= win) && (j - k <= win)) c++;
          if (c > 0) begin
            expA[expN] = 2 * j; expW[expN] = c; expN++;
          end
        end
      end
    end
  endtask

  task automatic runCrossing(input logic [127:0] h, input bit cm, input int mw, input int win,
                             input bit disturb, input string req);
    int cyc = 0;
    int n = 0;
    int firstCyc = 0;
    int doneCyc = 0;
    int lastRecCyc = 0;
    int lastCount = 0;
    bit done = 0;
    bit ovf = 0;
    int expEmit;
    buildExp(h, cm, mw, win);
    expEmit = (expN > 16) ? 16 : expN;
    @(negedge clk);
    hits = h; coinMode = cm; maxWidth = 4'(mw); winSize = 2'(win); start = 1'b1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
      end
      if (disturb && cyc == 4) begin
        start = 1'b1; hits = ~h; coinMode = ~cm; maxWidth = 4'd8; winSize = 2'd3;
      end
      if (disturb && cyc == 5) start = 1'b0;
      if (recValid) begin
        if (firstCyc == 0) firstCyc = cyc;
        if (n < 128) begin
          gotA[n] = int'(recAddr); gotW[n] = int'(recWidth); gotL[n] = int'(recLast);
        end
        if (recLast) lastCount++;
        lastRecCyc = cyc;
        n++;
      end
      if (crossDone) begin
        done = 1; doneCyc = cyc; ovf = crossOverflow;
        if (firstCyc == 0) firstCyc = cyc;
      end
    end
    chk(done, req, "crossing finished", int'(done), 1);
    if (!done) return;
    chk(firstCyc == 3, "R9", "first output cycle", firstCyc, 3);
    chk(n == expEmit, "R7", "record count", n, expEmit);
    for (int r = 0; r < n && r < expEmit; r++) begin
      chk(gotA[r] == expA[r], req, "record address", gotA[r], expA[r]);
      chk(gotW[r] == expW[r], req, "record width", gotW[r], expW[r]);
    end
    if (n > 0) begin
      chk(gotL[n-1] == 1 && lastCount == 1, "R5", "last flag on final record only", lastCount, 1);
      chk(doneCyc == lastRecCyc, "R6", "done with final record", doneCyc, lastRecCyc);
      chk(lastRecCyc - firstCyc == n - 1, "R5", "records on consecutive clocks", lastRecCyc - firstCyc, n - 1);
    end else begin
      chk(doneCyc == 3, "R6", "lone done cycle", doneCyc, 3);
    end
    chk(int'(ovf) == int'(expN > 16), "R7", "overflow flag", int'(ovf), int'(expN > 16));
    for (int q = 0; q < 6; q++) begin
      @(negedge clk);
      if (q == 0) chk(busy == 1'b0, "R9", "busy cleared after done", int'(busy), 0);
      chk(!recValid && !crossDone, disturb ? "R8" : "R6", "quiet after crossing",
          int'(recValid) + int'(crossDone), 0);
    end
  endtask

  task automatic testReset();
    chk(!busy && !recValid && !recLast && !crossDone && !crossOverflow, "R1", "outputs at reset",
        int'(busy) + int'(recValid) + int'(recLast) + int'(crossDone) + int'(crossOverflow), 0);
  endtask

  task automatic testClusters();
    logic [127:0] h = '0;
    h[2:0] = 3'b111; h[5] = 1'b1; h[19:10] = '1; h[63:60] = '1; h[127] = 1'b1;
    runCrossing(h, 1'b0, 8, 0, 1'b0, "R2");
    runCrossing(h, 1'b0, 3, 0, 1'b0, "R3");
    runCrossing(h, 1'b0, 0, 0, 1'b0, "R3");
    h = '0; h[37:30] = '1; h[40] = 1'b1;
    runCrossing(h, 1'b0, 7, 0, 1'b0, "R3");
  endtask

  task automatic testCoincidence();
    logic [127:0] h = '0;
    h[0] = 1'b1; h[1] = 1'b1;          // lower 0, upper 0
    h[20] = 1'b1; h[23] = 1'b1;        // lower 10, upper 11
    h[81] = 1'b1;                      // upper 40 alone
    h[126] = 1'b1; h[127] = 1'b1;      // lower 63, upper 63
    h[60] = 1'b1; h[55] = 1'b1; h[59] = 1'b1; h[67] = 1'b1; h[69] = 1'b1;
    runCrossing(h, 1'b1, 8, 0, 1'b0, "R4");
    runCrossing(h, 1'b1, 8, 1, 1'b0, "R4");
    runCrossing(h, 1'b1, 8, 3, 1'b0, "R4");
  endtask

  task automatic testOverflow();
    logic [127:0] h = '0;
    for (int i = 0; i < 128; i += 2) h[i] = 1'b1;
    runCrossing(h, 1'b0, 1, 0, 1'b1, "R7");
    h = '0;
    for (int i = 0; i < 32; i += 2) h[i] = 1'b1;
    runCrossing(h, 1'b0, 1, 0, 1'b0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClusters();
    testCoincidence();
    testOverflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule